// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block is a real-time clock peripheral with a 32-bit register interface. A prescaled tick pulse drives a sub-second counter. Each time that counter completes a second, a 32-bit seconds count advances. Software can load a new seconds value. The load takes effect at the next second boundary, and the sub-second phase restarts at the moment of the write. An alarm register is compared against the seconds count at every boundary.

Two interrupt groups each hold a status register, a mask register, and a pair of write-only enable/disable strobes. The mask cannot be written directly: it changes only through the strobes. The event group has two sources, the second boundary and the alarm match. The address-error group has one source, any access to an unmapped register index. Each group drives its own registered interrupt line.

The register port is a single-cycle request interface addressed by word index. Read data appears one cycle after the request.

Top module: `rtc_core`

## Requirements
- R1: Registers are 32 bits and addressed by word index: 0 LOAD, 1 NOW, 2 SUBSEC, 3 TRIM, 4 WAKE, 5 EVT_STAT, 6 EVT_MASK, 7 EVT_ON, 8 EVT_OFF, 9 ERR_STAT, 10 ERR_MASK, 11 ERR_ON, 12 ERR_OFF, 13 CTRL, 14 SCRATCH. Read data is valid on `rdata_o` in the cycle after the request. EVT_ON, EVT_OFF, ERR_ON and ERR_OFF read as zero.
- R2: SUBSEC counts `tick_i` pulses. On the TICKS_PER_SEC-th pulse it returns to 0 and the seconds count advances by one. NOW and LOAD both read the live seconds count, which is 0 after reset.
- R3: A write to LOAD clears SUBSEC at once. The seconds count keeps its old value until the next second boundary, where it takes the written value.
- R4: EVT_STAT bit 0 is set at every second boundary. EVT_STAT bit 1 is set at a boundary when the value the seconds count takes equals WAKE. WAKE is read/write.
- R5: Writing EVT_STAT clears each bit written as 1 and leaves each bit written as 0. A source event in the same cycle wins over the clear.
- R6: EVT_MASK resets to 0x3 and ignores direct writes. Writing EVT_ON clears the mask bits given as ones. Writing EVT_OFF sets the mask bits given as ones.
- R7: `evt_irq_o` is high, one cycle after the fact, exactly when some EVT_STAT bit is set whose EVT_MASK bit is clear.
- R8: A read or write to an index above 14 sets ERR_STAT bit 0. Such a read returns 0, and such a write changes nothing else.
- R9: ERR_STAT is write-one-to-clear. ERR_MASK resets to 1 and changes only through ERR_ON (clear) and ERR_OFF (set). `err_irq_o` follows ERR_STAT and ERR_MASK with one cycle of lag.
- R10: CTRL resets to 0x01000000. Only bits 31, 27:24 and 0 are writable; all other bits read as zero.
- R11: SCRATCH is a full 32-bit read/write register. TRIM reads the 21-bit TRIM_VALUE parameter. Writes to NOW, SUBSEC and TRIM are ignored and do not raise an address error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled tick pulse, one cycle wide |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | ADDR_W | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| evt_irq_o | output | 1 | Event interrupt (second boundary / alarm) |
| err_irq_o | output | 1 | Address-error interrupt |

## Verification
The assertions check the following on every cycle:
- the sub-second counter stays below its limit;
- every boundary not pre-empted by a load sets event bit 0;
- the event mask moves only on enable/disable writes;
- the event line tracks status and mask with one cycle of lag;
- unmapped accesses raise the error flag;
- the reserved control bits stay zero.

Only the directed scenarios can show the following:
- a load that holds until the next boundary;
- an alarm that matches only on the second it names;
- write-one-to-clear writes that leave the zero bits alone;
- direct mask writes being ignored;
- unmapped writes leaving the other registers untouched.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W = 32;

  localparam int IDX_LOAD     = 0;
  localparam int IDX_NOW      = 1;
  localparam int IDX_SUBSEC   = 2;
  localparam int IDX_TRIM     = 3;
  localparam int IDX_WAKE     = 4;
  localparam int IDX_EVT_STAT = 5;
  localparam int IDX_EVT_MASK = 6;
  localparam int IDX_EVT_ON   = 7;
  localparam int IDX_EVT_OFF  = 8;
  localparam int IDX_ERR_STAT = 9;
  localparam int IDX_ERR_MASK = 10;
  localparam int IDX_ERR_ON   = 11;
  localparam int IDX_ERR_OFF  = 12;
  localparam int IDX_CTRL     = 13;
  localparam int IDX_SCRATCH  = 14;
  localparam int IDX_LAST     = IDX_SCRATCH;

  localparam logic [REG_W-1:0] CTRL_RESET = 32'h0100_0000;
  localparam logic [REG_W-1:0] CTRL_WMASK = 32'h8F00_0001;

  localparam int EVT_W = 2;
  localparam int ERR_W = 1;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SUBSEC_W      = 16,
  parameter int SEC_W         = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                load_i,
  input  logic [SEC_W-1:0]    load_val_i,
  output logic [SEC_W-1:0]    sec_o,
  output logic [SUBSEC_W-1:0] subsec_o,
  output logic                wrap_o,
  output logic [SEC_W-1:0]    sec_next_o
);
  localparam logic [SUBSEC_W-1:0] LAST = SUBSEC_W'(TICKS_PER_SEC - 1);

  logic [SEC_W-1:0]    sec_q;
  logic [SUBSEC_W-1:0] sub_q;
  logic                pend_q;
  logic [SEC_W-1:0]    pend_val_q;

  // A load write discards a tick that arrives in the same cycle.
  assign wrap_o     = tick_i && !load_i && (sub_q == LAST);
  assign sec_next_o = pend_q ? pend_val_q : sec_q + SEC_W'(1);
  assign sec_o      = sec_q;
  assign subsec_o   = sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q      <= '0;
      sub_q      <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (load_i) begin
      sub_q      <= '0;
      pend_q     <= 1'b1;
      pend_val_q <= load_val_i;
    end else if (tick_i) begin
      if (sub_q == LAST) begin
        sub_q  <= '0;
        sec_q  <= sec_next_o;
        pend_q <= 1'b0;
      end else begin
        sub_q <= sub_q + SUBSEC_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_irq_bank.sv
module rtc_irq_bank #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic         on_wr_i,
  input  logic         off_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, mask_q;
  logic [W-1:0] clr_bits;
  logic         irq_q;

  assign clr_bits = clr_wr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | set_i;
      if (on_wr_i)
        mask_q <= mask_q & ~wdata_i;
      else if (off_wr_i)
        mask_q <= mask_q | wdata_i;
      irq_q <= |(stat_q & ~mask_q);
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int          ADDR_W        = 4,
  parameter int          TICKS_PER_SEC = 32768,
  parameter int          SUBSEC_W      = 16,
  parameter logic [20:0] TRIM_VALUE    = 21'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              evt_irq_o,
  output logic              err_irq_o
);
  logic [31:0] idx_ext;
  logic        mapped, wr, rd_unmapped_unused;
  logic [31:0] sec, sec_next, wake_q, ctrl_q, scratch_q, rdata_q, rd_mux;
  logic [SUBSEC_W-1:0] subsec;
  logic        wrap;
  logic [EVT_W-1:0] evt_stat, evt_mask, evt_set;
  logic [ERR_W-1:0] err_stat, err_mask, err_set;

  assign idx_ext = 32'(idx_i);
  assign mapped  = idx_ext <= 32'(IDX_LAST);
  assign wr      = req_i && we_i;
  assign rd_unmapped_unused = 1'b0;

  rtc_timebase #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .SUBSEC_W(SUBSEC_W), .SEC_W(32)
  ) i_timebase (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .load_i(wr && idx_ext == 32'(IDX_LOAD)), .load_val_i(wdata_i),
    .sec_o(sec), .subsec_o(subsec), .wrap_o(wrap), .sec_next_o(sec_next)
  );

  assign evt_set = {wrap && (sec_next == wake_q), wrap};
  assign err_set = ERR_W'(req_i && !mapped);

  rtc_irq_bank #(.W(EVT_W)) i_evt_bank (
    .clk(clk), .rst(rst), .set_i(evt_set),
    .clr_wr_i(wr && idx_ext == 32'(IDX_EVT_STAT)),
    .on_wr_i (wr && idx_ext == 32'(IDX_EVT_ON)),
    .off_wr_i(wr && idx_ext == 32'(IDX_EVT_OFF)),
    .wdata_i(wdata_i[EVT_W-1:0]),
    .stat_o(evt_stat), .mask_o(evt_mask), .irq_o(evt_irq_o)
  );

  rtc_irq_bank #(.W(ERR_W)) i_err_bank (
    .clk(clk), .rst(rst), .set_i(err_set),
    .clr_wr_i(wr && idx_ext == 32'(IDX_ERR_STAT)),
    .on_wr_i (wr && idx_ext == 32'(IDX_ERR_ON)),
    .off_wr_i(wr && idx_ext == 32'(IDX_ERR_OFF)),
    .wdata_i(wdata_i[ERR_W-1:0]),
    .stat_o(err_stat), .mask_o(err_mask), .irq_o(err_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q    <= '0;
      ctrl_q    <= CTRL_RESET;
      scratch_q <= '0;
    end else if (wr) begin
      if (idx_ext == 32'(IDX_WAKE))    wake_q    <= wdata_i;
      if (idx_ext == 32'(IDX_CTRL))    ctrl_q    <= wdata_i & CTRL_WMASK;
      if (idx_ext == 32'(IDX_SCRATCH)) scratch_q <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (idx_ext)
      IDX_LOAD, IDX_NOW: rd_mux = sec;
      IDX_SUBSEC:        rd_mux = 32'(subsec);
      IDX_TRIM:          rd_mux = 32'(TRIM_VALUE);
      IDX_WAKE:          rd_mux = wake_q;
      IDX_EVT_STAT:      rd_mux = 32'(evt_stat);
      IDX_EVT_MASK:      rd_mux = 32'(evt_mask);
      IDX_ERR_STAT:      rd_mux = 32'(err_stat);
      IDX_ERR_MASK:      rd_mux = 32'(err_mask);
      IDX_CTRL:          rd_mux = ctrl_q;
      IDX_SCRATCH:       rd_mux = scratch_q;
      default:           rd_mux = 32'(rd_unmapped_unused);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (req_i && !we_i)
      rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
  parameter int ADDR_W        = 4,
  parameter int TICKS_PER_SEC = 32768,
  parameter int SUBSEC_W      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] idx_i,
  input logic              evt_irq_o,
  input logic [1:0]        evt_stat,
  input logic [1:0]        evt_mask,
  input logic [0:0]        err_stat,
  input logic [31:0]       ctrl_q,
  input logic [SUBSEC_W-1:0] subsec
);
  localparam logic [SUBSEC_W-1:0] LAST = SUBSEC_W'(TICKS_PER_SEC - 1);
  logic [31:0] ix;
  assign ix = 32'(idx_i);

  a_r2_subsec_range: assert property (@(posedge clk) disable iff (rst)
    subsec <= LAST);

  a_r4_boundary_sets: assert property (@(posedge clk) disable iff (rst)
    (tick_i && subsec == LAST && !(req_i && we_i && ix == 32'd0)) |=> evt_stat[0]);

  a_r6_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !(req_i && we_i && (ix == 32'd7 || ix == 32'd8)) |=> $stable(evt_mask));

  a_r7_irq_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (evt_irq_o == $past(|(evt_stat & ~evt_mask))));

  a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
    (req_i && ix > 32'd14) |=> err_stat[0]);

  a_r10_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & 32'h70FF_FFFE) == 32'h0);
endmodule

bind rtc_core rtc_chk #(
  .ADDR_W(ADDR_W), .TICKS_PER_SEC(TICKS_PER_SEC), .SUBSEC_W(SUBSEC_W)
) i_rtc_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
  .idx_i(idx_i), .evt_irq_o(evt_irq_o), .evt_stat(evt_stat),
  .evt_mask(evt_mask), .err_stat(err_stat), .ctrl_q(ctrl_q), .subsec(subsec)
);

// File: tb/test_rtc_core.sv
module test_rtc_core;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [3:0]  idx = '0;
  logic [31:0] wdata = '0, rdata;
  logic evt_irq, err_irq;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_core #(.ADDR_W(4), .TICKS_PER_SEC(TPS), .SUBSEC_W(16), .TRIM_VALUE(21'h12345))
  i_rtc_core (
    .clk(clk), .rst(rst), .tick_i(tick), .req_i(req), .we_i(we), .idx_i(idx),
    .wdata_i(wdata), .rdata_o(rdata), .evt_irq_o(evt_irq), .err_irq_o(err_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; idx = 4'(i); wdata = d;
    @(posedge clk); @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int i, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; idx = 4'(i);
    @(posedge clk); @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(posedge clk); @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    rd(6, v);  check("R6 evt mask reset", v, 32'h3);
    rd(10, v); check("R9 err mask reset", v, 32'h1);
    rd(13, v); check("R10 ctrl reset", v, 32'h0100_0000);
    rd(1, v);  check("R2 seconds reset", v, 32'h0);
    rd(5, v);  check("R5 evt stat reset", v, 32'h0);
    check("R7 evt irq reset", 32'(evt_irq), 32'h0);
    check("R9 err irq reset", 32'(err_irq), 32'h0);
  endtask

  task automatic t_count();
    ticks(3);
    rd(2, v); check("R2 subsec counts", v, 32'd3);
    rd(1, v); check("R2 no wrap early", v, 32'd0);
    ticks(1);
    rd(1, v); check("R2 seconds advance", v, 32'd1);
    rd(0, v); check("R2 load readback live", v, 32'd1);
    rd(2, v); check("R2 subsec wraps", v, 32'd0);
    rd(5, v); check("R4 boundary sets bit0", v, 32'h1);
    check("R7 masked irq low", 32'(evt_irq), 32'h0);
  endtask

  task automatic t_mask();
    wr(7, 32'h1); idle();
    rd(6, v); check("R6 enable clears bit", v, 32'h2);
    check("R7 irq after enable", 32'(evt_irq), 32'h1);
    rd(7, v); check("R1 enable reads zero", v, 32'h0);
    wr(6, 32'h3);
    rd(6, v); check("R6 direct mask write ignored", v, 32'h2);
  endtask

  task automatic t_w1c();
    wr(5, 32'h2);
    rd(5, v); check("R5 zero bit kept", v, 32'h1);
    wr(5, 32'h1); idle();
    rd(5, v); check("R5 one bit cleared", v, 32'h0);
    check("R7 irq drops after clear", 32'(evt_irq), 32'h0);
  endtask

  task automatic t_disable();
    ticks(4); idle();
    check("R7 irq on next second", 32'(evt_irq), 32'h1);
    wr(8, 32'h1); idle();
    rd(6, v); check("R6 disable sets bit", v, 32'h3);
    check("R7 irq low after disable", 32'(evt_irq), 32'h0);
    wr(5, 32'h3);
  endtask

  task automatic t_alarm();
    wr(4, 32'd4);
    ticks(4);
    rd(5, v); check("R4 no alarm at 3", v, 32'h1);
    wr(5, 32'h3);
    ticks(4);
    rd(1, v); check("R2 reached 4", v, 32'd4);
    rd(5, v); check("R4 alarm at 4", v, 32'h3);
    rd(4, v); check("R4 wake readback", v, 32'd4);
    wr(7, 32'h2); idle();
    check("R7 alarm irq", 32'(evt_irq), 32'h1);
    wr(5, 32'h3); idle(); idle();
    check("R7 irq after alarm clear", 32'(evt_irq), 32'h0);
    wr(8, 32'h3);
  endtask

  task automatic t_load();
    ticks(2);
    wr(0, 32'd100);
    rd(2, v); check("R3 load clears subsec", v, 32'd0);
    rd(1, v); check("R3 old seconds kept", v, 32'd4);
    ticks(3);
    rd(1, v); check("R3 not before boundary", v, 32'd4);
    ticks(1);
    rd(1, v); check("R3 loaded at boundary", v, 32'd100);
    rd(0, v); check("R3 load readback", v, 32'd100);
    wr(5, 32'h3);
  endtask

  task automatic t_ctrl_misc();
    wr(13, 32'hFFFF_FFFF);
    rd(13, v); check("R10 writable ctrl bits", v, 32'h8F00_0001);
    wr(13, 32'h0);
    rd(13, v); check("R10 ctrl clear", v, 32'h0);
    wr(14, 32'hDEAD_BEEF);
    rd(14, v); check("R11 scratch rw", v, 32'hDEAD_BEEF);
    wr(1, 32'd7);
    rd(1, v); check("R11 now write ignored", v, 32'd100);
    wr(3, 32'hFFFF_FFFF);
    rd(3, v); check("R11 trim readback", v, 32'h0001_2345);
    rd(9, v); check("R11 ro writes not errors", v, 32'h0);
  endtask

  task automatic t_addr_err();
    rd(15, v); check("R8 unmapped read zero", v, 32'h0);
    rd(9, v);  check("R8 flag set by read", v, 32'h1);
    check("R9 err irq masked", 32'(err_irq), 32'h0);
    wr(11, 32'h1); idle();
    rd(10, v); check("R9 err mask enabled", v, 32'h0);
    check("R9 err irq high", 32'(err_irq), 32'h1);
    wr(9, 32'h1); idle();
    rd(9, v); check("R9 err flag w1c", v, 32'h0);
    check("R9 err irq cleared", 32'(err_irq), 32'h0);
    wr(15, 32'h55);
    rd(9, v);  check("R8 flag set by write", v, 32'h1);
    rd(14, v); check("R8 write no effect scratch", v, 32'hDEAD_BEEF);
    rd(13, v); check("R8 write no effect ctrl", v, 32'h0);
    wr(12, 32'h1);
    rd(10, v); check("R9 err mask disabled", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_count();
    t_mask();
    t_w1c();
    t_disable();
    t_alarm();
    t_load();
    t_ctrl_misc();
    t_addr_err();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule